// File: doc/BRIEF.md
# Eight-bit PWM timer/counter

This block is an 8-bit timer/counter with a single output compare channel. It advances once per timer tick, a one-cycle enable that an external prescaler supplies. A 3-bit clock select gates those ticks: the value zero stops the counter, and any other value lets the ticks through. Four waveform modes set how the counter moves and how the compare channel drives the waveform pin. The modes are free-running up-count, clear on compare, single-slope fast PWM, and dual-slope phase-correct PWM.

Software reaches the block through a small write port. The port loads either the counter or the compare register. A force strobe applies the compare-output action at once, without waiting for a match. An overflow flag and a compare-match flag record events, and each flag is cleared by writing one to its bit of the flag-clear input. The counter value is brought out so it can be observed.

Top module: `pwm_timer`

## Requirements
- R1: A tick counts only when `tick_en` is 1 and `clk_sel` is nonzero. Without a tick, and without a counter write, the counter holds its value.
- R2: With `wave_mode`=0 (normal) the counter counts up and wraps from 0xFF to 0x00. The overflow event fires on the tick taken at 0xFF.
- R3: With `wave_mode`=2 (clear on compare), a tick that produces a compare match loads 0x00 into the counter. Otherwise the counter counts up, and the overflow event fires on the tick taken at 0xFF.
- R4: With `wave_mode`=3 (fast PWM) the counter counts up and wraps after 0xFF, and the overflow event fires on the tick at 0xFF. Compare-output mode 1 toggles the pin on a match. Mode 2 clears the pin on a match and sets it at the wrap. Mode 3 does the reverse. When a match and a wrap happen on the same tick, the wrap action wins.
- R5: With `wave_mode`=1 (phase-correct) the counter counts 0 up to 0xFF, then down to 0, and repeats. The overflow event fires on the tick that brings it from 1 to 0. Compare-output mode 2 clears the pin on a match while counting up and sets it on a match while counting down. Mode 3 does the reverse, and mode 1 takes no action.
- R6: In the normal and clear-on-compare modes, a compare-register write (`wr_addr`=1) takes effect on the next cycle. In the two PWM modes the write goes to a buffer. The buffer moves to the active compare value on the tick at 0xFF (fast PWM) or on the tick at 0xFF while counting up (phase-correct).
- R7: A counter write (`wr_addr`=0) takes priority over a tick in the same cycle. No compare match happens in that cycle or on the next tick.
- R8: In the non-PWM modes, `force_cmp` applies the compare-output action to the pin. It sets no flag and does not touch the counter. In the PWM modes it has no effect.
- R9: Compare-output mode 0 drives `wave_out` low. In the non-PWM modes a match toggles the pin (mode 1), clears it (mode 2) or sets it (mode 3).
- R10: The overflow and match events set `ovf_flag` and `cmp_flag`. Writing 1 to `flag_clr[0]` or `flag_clr[1]` clears the matching flag. If a flag is set and cleared in the same cycle, the set wins.
- R11: After a synchronous reset the counter is 0 and counts up. The pin state, both flags, the compare value and its buffer are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Timer tick enable from the prescaler |
| clk_sel | input | 3 | Clock select; zero stops the counter |
| wave_mode | input | 2 | 0 normal, 1 phase-correct, 2 clear on compare, 3 fast PWM |
| out_mode | input | 2 | Compare-output mode 0..3 |
| force_cmp | input | 1 | Force-compare strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 counter, 1 compare register |
| wr_data | input | CNT_W | Write data |
| flag_clr | input | 2 | Write one to clear: bit 0 overflow, bit 1 match |
| wave_out | output | 1 | Compare waveform pin |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |
| count | output | CNT_W | Current counter value |

## Verification
Two things can fall in the same cycle. A flag-setting event can coincide with a write-one clear of that flag, and a counter write can coincide with a tick that would have matched. The bench provokes the first directly: it loads 0xFF into the counter and then ticks while pulsing `flag_clr[0]`. The overflow flag must survive that cycle and clear on the following one. Throughout the mode, output-mode and compare-value sweeps, the bench also pulses both clear bits periodically, so they collide with events across all four modes. Every cycle is judged against an arithmetic model of the requirements.

// File: rtl/pwm_timer_pkg.sv
// Package: shared encodings for the PWM timer.
// Assumes: wave-mode encoding has bit 0 set for both PWM modes.
package pwm_timer_pkg;

    typedef enum logic [1:0] {
        WM_NORMAL = 2'd0,
        WM_PHASE  = 2'd1,
        WM_CTC    = 2'd2,
        WM_FAST   = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_CLEAR  = 2'd2,
        OM_SET    = 2'd3
    } out_mode_e;

    function automatic logic mode_is_pwm(wave_mode_e m);
        return (m == WM_PHASE) || (m == WM_FAST);
    endfunction

endpackage

// File: rtl/pwm_timer_counter.sv
// Counter unit: holds the count and the phase-correct direction, and
// produces the per-tick overflow and top events.
// Assumes: match_evt is already qualified by tick and write blocking.
module pwm_timer_counter
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  wave_mode_e   mode,
    input  logic         wr_cnt,
    input  logic [W-1:0] wr_data,
    input  logic         match_evt,
    output logic [W-1:0] cnt,
    output logic         count_up,
    output logic         ovf_evt,
    output logic         top_evt
);
    localparam logic [W-1:0] MAXV = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] nxt_cnt;
    logic         nxt_up;
    logic         ovf_c;
    logic         top_c;

    // Next count, direction and events for a tick in the current mode.
    always_comb begin
        nxt_cnt = cnt;
        nxt_up  = count_up;
        ovf_c   = 1'b0;
        top_c   = 1'b0;
        unique case (mode)
            WM_NORMAL: begin
                nxt_cnt = cnt + ONE;
                ovf_c   = (cnt == MAXV);
            end
            WM_CTC: begin
                nxt_cnt = match_evt ? '0 : cnt + ONE;
                ovf_c   = (cnt == MAXV);
            end
            WM_FAST: begin
                nxt_cnt = cnt + ONE;
                ovf_c   = (cnt == MAXV);
                top_c   = (cnt == MAXV);
            end
            WM_PHASE: begin
                if (count_up) begin
                    if (cnt == MAXV) begin
                        nxt_cnt = MAXV - ONE;
                        nxt_up  = 1'b0;
                        top_c   = 1'b1;
                    end else begin
                        nxt_cnt = cnt + ONE;
                    end
                end else begin
                    if (cnt == '0) begin
                        nxt_cnt = ONE;
                        nxt_up  = 1'b1;
                    end else begin
                        nxt_cnt = cnt - ONE;
                        ovf_c   = (cnt == ONE);
                    end
                end
            end
            default: nxt_cnt = cnt;
        endcase
    end

    assign ovf_evt = tick && !wr_cnt && ovf_c;
    assign top_evt = tick && !wr_cnt && top_c;

    // Count register: a write wins over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            count_up <= 1'b1;
        end else if (wr_cnt) begin
            cnt <= wr_data;
        end else if (tick) begin
            cnt      <= nxt_cnt;
            count_up <= nxt_up;
        end
    end

    assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt));

    assert_ctc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_CTC && match_evt) |=> (cnt == '0));

    assert_write_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wr_data)));

endmodule

// File: rtl/pwm_timer_compare.sv
// Compare unit: active compare value, PWM buffer and match detection
// with one-tick blocking after a counter write.
// Assumes: load is the counter unit's top event.
module pwm_timer_compare
    import pwm_timer_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         pwm,
    input  logic         wr_cnt,
    input  logic         wr_cmp,
    input  logic [W-1:0] wr_data,
    input  logic         load,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] cmp_val,
    output logic         match_evt
);
    logic [W-1:0] cmp_buf;
    logic         blocked;

    assign match_evt = tick && !wr_cnt && !blocked && (cnt == cmp_val);

    // Blocking state: set by a counter write, dropped by the next tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      blocked <= 1'b0;
        else if (wr_cnt) blocked <= 1'b1;
        else if (tick)   blocked <= 1'b0;
    end

    // Buffer and active value: direct outside PWM, transfer at top in PWM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_buf <= '0;
            cmp_val <= '0;
        end else begin
            if (wr_cmp) cmp_buf <= wr_data;
            if (wr_cmp && !pwm)    cmp_val <= wr_data;
            else if (load && pwm)  cmp_val <= cmp_buf;
        end
    end

    assert_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmp && !pwm) |=> (cmp_val == $past(wr_data)));

    assert_buffered_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load) |=> $stable(cmp_val));

    assert_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> !match_evt);

endmodule

// File: rtl/pwm_timer_waveout.sv
// Waveform output unit: applies match, wrap and force actions to the
// pin state according to the waveform and compare-output modes.
// Assumes: count_up is the direction before the current tick.
module pwm_timer_waveout
    import pwm_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wave_mode_e mode,
    input  out_mode_e  om,
    input  logic       force_cmp,
    input  logic       match_evt,
    input  logic       top_evt,
    input  logic       count_up,
    output logic       wave_out
);
    logic oc_q;
    logic oc_nxt;
    logic pwm;

    assign pwm = mode_is_pwm(mode);

    // Next pin state; in fast PWM the wrap action overrides a match.
    always_comb begin
        oc_nxt = oc_q;
        if (!pwm) begin
            if (match_evt || force_cmp) begin
                case (om)
                    OM_TOGGLE: oc_nxt = !oc_q;
                    OM_CLEAR:  oc_nxt = 1'b0;
                    OM_SET:    oc_nxt = 1'b1;
                    default:   oc_nxt = oc_q;
                endcase
            end
        end else if (mode == WM_FAST) begin
            if (match_evt) begin
                case (om)
                    OM_TOGGLE: oc_nxt = !oc_q;
                    OM_CLEAR:  oc_nxt = 1'b0;
                    OM_SET:    oc_nxt = 1'b1;
                    default:   oc_nxt = oc_q;
                endcase
            end
            if (top_evt) begin
                if (om == OM_CLEAR) oc_nxt = 1'b1;
                if (om == OM_SET)   oc_nxt = 1'b0;
            end
        end else begin
            if (match_evt) begin
                if (om == OM_CLEAR) oc_nxt = !count_up;
                if (om == OM_SET)   oc_nxt = count_up;
            end
        end
    end

    // Pin state register.
    always_ff @(posedge clk) begin
        if (!rst_n) oc_q <= 1'b0;
        else        oc_q <= oc_nxt;
    end

    assign wave_out = (om == OM_OFF) ? 1'b0 : oc_q;

    assert_force_pwm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !match_evt && !top_evt) |=> $stable(oc_q));

    assert_fast_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == WM_FAST && om == OM_CLEAR && top_evt) |=> oc_q);

endmodule

// File: rtl/pwm_timer.sv
// Top: eight-bit PWM timer/counter with one compare channel.
// Ties the counter, compare and waveform units together and owns the
// write-one-to-clear event flags.
// Assumes: tick_en is a one-cycle enable from an external prescaler.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic [2:0]       clk_sel,
    input  logic [1:0]       wave_mode,
    input  logic [1:0]       out_mode,
    input  logic             force_cmp,
    input  logic             wr_en,
    input  logic             wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       flag_clr,
    output logic             wave_out,
    output logic             ovf_flag,
    output logic             cmp_flag,
    output logic [CNT_W-1:0] count
);
    wave_mode_e       mode;
    out_mode_e        om;
    logic             tick;
    logic             wr_cnt;
    logic             wr_cmp;
    logic             count_up;
    logic             ovf_evt;
    logic             top_evt;
    logic             match_evt;
    logic [CNT_W-1:0] cmp_val;

    assign mode   = wave_mode_e'(wave_mode);
    assign om     = out_mode_e'(out_mode);
    assign tick   = tick_en && (clk_sel != 3'd0);
    assign wr_cnt = wr_en && !wr_addr;
    assign wr_cmp = wr_en && wr_addr;

    pwm_timer_counter #(.W(CNT_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .mode      (mode),
        .wr_cnt    (wr_cnt),
        .wr_data   (wr_data),
        .match_evt (match_evt),
        .cnt       (count),
        .count_up  (count_up),
        .ovf_evt   (ovf_evt),
        .top_evt   (top_evt)
    );

    pwm_timer_compare #(.W(CNT_W)) u_compare (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pwm       (mode_is_pwm(mode)),
        .wr_cnt    (wr_cnt),
        .wr_cmp    (wr_cmp),
        .wr_data   (wr_data),
        .load      (top_evt),
        .cnt       (count),
        .cmp_val   (cmp_val),
        .match_evt (match_evt)
    );

    pwm_timer_waveout u_waveout (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (mode),
        .om        (om),
        .force_cmp (force_cmp),
        .match_evt (match_evt),
        .top_evt   (top_evt),
        .count_up  (count_up),
        .wave_out  (wave_out)
    );

    // Event flags: a set in the same cycle beats a write-one clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            cmp_flag <= 1'b0;
        end else begin
            ovf_flag <= ovf_evt   || (ovf_flag && !flag_clr[0]);
            cmp_flag <= match_evt || (cmp_flag && !flag_clr[1]);
        end
    end

    assert_ovf_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> ovf_flag);

    assert_cmp_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_evt |=> cmp_flag);

    assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr[0] && !ovf_evt) |=> !ovf_flag);

    assert_force_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (force_cmp && !match_evt && !cmp_flag) |=> !cmp_flag);

endmodule

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] clk_sel = 3'd0;
    logic [1:0] wave_mode = 2'd0;
    logic [1:0] out_mode = 2'd0;
    logic       force_cmp = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic [1:0] flag_clr = 2'd0;
    logic       wave_out, ovf_flag, cmp_flag;
    logic [7:0] count;

    int errs = 0;
    int checks = 0;
    string cur_tag = "R11";

    // model state
    int m_cnt, m_act, m_buf;
    bit m_up, m_oc, m_ovf, m_cf, m_blk;

    always #4 clk = ~clk;

    pwm_timer u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .clk_sel(clk_sel),
        .wave_mode(wave_mode), .out_mode(out_mode), .force_cmp(force_cmp),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .flag_clr(flag_clr),
        .wave_out(wave_out), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag), .count(count)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic apply_om();
        case (out_mode)
            2'd1: m_oc = !m_oc;
            2'd2: m_oc = 1'b0;
            2'd3: m_oc = 1'b1;
            default: ;
        endcase
    endtask

    // Next model state from current drives, per the requirements.
    task automatic model_step();
        bit tk, wc, wo, pwm, hit, ov, tp, nu;
        int n;
        if (!rst_n) begin
            m_cnt = 0; m_up = 1; m_oc = 0; m_ovf = 0; m_cf = 0;
            m_act = 0; m_buf = 0; m_blk = 0;
            return;
        end
        tk  = tick_en && (clk_sel != 0);
        wc  = wr_en && !wr_addr;
        wo  = wr_en && wr_addr;
        pwm = (wave_mode == 2'd1) || (wave_mode == 2'd3);
        hit = tk && !wc && !m_blk && (m_cnt == m_act);
        ov = 0; tp = 0; n = m_cnt; nu = m_up;
        if (tk && !wc) begin
            case (wave_mode)
                2'd0: begin n = (m_cnt + 1) % 256; ov = (m_cnt == 255); end
                2'd2: begin n = hit ? 0 : (m_cnt + 1) % 256; ov = (m_cnt == 255); end
                2'd3: begin n = (m_cnt + 1) % 256; ov = (m_cnt == 255); tp = ov; end
                default: begin
                    if (m_up) begin
                        if (m_cnt == 255) begin n = 254; nu = 0; tp = 1; end
                        else n = m_cnt + 1;
                    end else begin
                        if (m_cnt == 0) begin n = 1; nu = 1; end
                        else begin n = m_cnt - 1; ov = (m_cnt == 1); end
                    end
                end
            endcase
        end
        if (wc) n = wr_data;
        if (!pwm) begin
            if (hit || force_cmp) apply_om();
        end else if (wave_mode == 2'd3) begin
            if (hit) apply_om();
            if (tp && out_mode == 2'd2) m_oc = 1;
            if (tp && out_mode == 2'd3) m_oc = 0;
        end else if (hit) begin
            if (out_mode == 2'd2) m_oc = !m_up;
            if (out_mode == 2'd3) m_oc = m_up;
        end
        m_ovf = ov || (m_ovf && !flag_clr[0]);
        m_cf  = hit || (m_cf && !flag_clr[1]);
        if (wc) m_blk = 1; else if (tk) m_blk = 0;
        if (wo && !pwm) m_act = wr_data;
        else if (tp && pwm) m_act = m_buf;
        if (wo) m_buf = wr_data;
        m_cnt = n; m_up = nu;
    endtask

    // One clock: model, edge, compare at the falling edge.
    task automatic cycle();
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({cur_tag, " count"}, count, m_cnt);
        chk({cur_tag, " wave"}, wave_out, (out_mode == 0) ? 0 : m_oc);
        chk({cur_tag, " ovf_flag"}, ovf_flag, m_ovf);
        chk({cur_tag, " cmp_flag"}, cmp_flag, m_cf);
    endtask

    task automatic idle();
        tick_en = 0; force_cmp = 0; wr_en = 0; flag_clr = 0; clk_sel = 0;
    endtask

    task automatic do_reset();
        idle(); rst_n = 0; cycle(); cycle(); rst_n = 1;
    endtask

    task automatic write_reg(bit addr, int val);
        wr_en = 1; wr_addr = addr; wr_data = val[7:0]; cycle(); wr_en = 0;
    endtask

    task automatic run_ticks(int n);
        clk_sel = 3'd1; tick_en = 1;
        for (int i = 0; i < n; i++) cycle();
        tick_en = 0;
    endtask

    initial begin
        #1_500_000;
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        // R11: reset state
        cur_tag = "R11";
        do_reset();
        chk("R11 count", count, 0);
        chk("R11 wave", wave_out, 0);
        chk("R11 ovf", ovf_flag, 0);
        chk("R11 cmp", cmp_flag, 0);

        // R1: ticks ignored with clock select zero
        cur_tag = "R1";
        tick_en = 1; clk_sel = 0;
        for (int i = 0; i < 10; i++) cycle();
        chk("R1 hold", count, 0);
        clk_sel = 3'd5;
        for (int i = 0; i < 3; i++) cycle();
        chk("R1 counts", count, 3);
        idle();

        // Sweep: waveform mode x output mode x compare value
        for (int md = 0; md < 4; md++) begin
            for (int o = 0; o < 4; o++) begin
                for (int k = 0; k < 3; k++) begin
                    int cv;
                    cv = (k == 0) ? 0 : (k == 1) ? 90 : 255;
                    case (md)
                        0: cur_tag = (o == 0) ? "R2/R9" : "R2/R9 normal";
                        1: cur_tag = "R5 phase";
                        2: cur_tag = "R3 ctc";
                        default: cur_tag = "R4 fast";
                    endcase
                    do_reset();
                    wave_mode = md[1:0]; out_mode = o[1:0];
                    write_reg(1, cv);
                    clk_sel = 3'd2;
                    for (int c = 0; c < 700; c++) begin
                        tick_en  = (c % 4) != 3;
                        flag_clr = (c % 37 == 0) ? 2'b11 : 2'b00;
                        cycle();
                    end
                    idle();
                end
            end
        end

        // R7: counter write blocks the next match
        cur_tag = "R7";
        do_reset(); wave_mode = 0; out_mode = 1;
        write_reg(1, 10);
        write_reg(0, 10);
        run_ticks(1);
        chk("R7 no match after write", cmp_flag, 0);
        chk("R7 count", count, 11);
        write_reg(0, 9);
        run_ticks(2);
        chk("R7 match later", cmp_flag, 1);

        // R8: force in non-PWM and PWM modes
        cur_tag = "R8";
        do_reset(); wave_mode = 0; out_mode = 1;
        write_reg(1, 200);
        write_reg(0, 33);
        force_cmp = 1; cycle(); force_cmp = 0; cycle();
        chk("R8 force toggles", wave_out, 1);
        chk("R8 no flag", cmp_flag, 0);
        chk("R8 count untouched", count, 33);
        wave_mode = 3; cycle();
        force_cmp = 1; cycle(); force_cmp = 0; cycle();
        chk("R8 ignored in PWM", wave_out, 1);

        // R6: buffered compare in fast PWM
        cur_tag = "R6";
        do_reset(); wave_mode = 3; out_mode = 2;
        write_reg(1, 48);
        run_ticks(16);
        chk("R6 old value matched", cmp_flag, 1);
        flag_clr = 2'b10; cycle(); flag_clr = 0;
        run_ticks(48);
        chk("R6 new value not yet active", cmp_flag, 0);
        run_ticks(192);
        run_ticks(32);
        chk("R6 old value gone after top", cmp_flag, 0);
        run_ticks(17);
        chk("R6 new value matched", cmp_flag, 1);

        // R10: set and clear in the same cycle
        cur_tag = "R10";
        do_reset(); wave_mode = 0;
        write_reg(0, 255);
        flag_clr = 2'b01; run_ticks(1); flag_clr = 0;
        chk("R10 set wins", ovf_flag, 1);
        flag_clr = 2'b01; cycle(); flag_clr = 0;
        chk("R10 clear", ovf_flag, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule